// File: doc/BRIEF.md
# Stereo Serial Port Clock Master

This block derives the two clocks of a stereo audio serial port from one master clock: a frame clock that runs at the sample rate Fs and a bit clock that runs at 64×Fs. A two-bit speed pin picks one of three master speeds or hands clock ownership to another device. A configuration pin states whether the master clock is the slow multiple of Fs or twice that ("fast"). In the fast case an extra divide-by-two stage is applied, so the output rates do not depend on which multiple is fitted.

The logic runs on `clk_i`, which ticks at twice the master-clock rate. One master-clock period is therefore two ticks. This lets even the quad-speed slow case, whose bit clock equals the master clock, come out as a registered clock with a 50% duty cycle. The frame clock is low for the left channel. A one-tick strobe marks the start of every left half so that a downstream serializer can load its next sample. This port carries no data stream, so there is no valid/ready handshake. Every pin is plain control or clock.

Top module: `audio_clk_master`

## Requirements
- R1: Speed pins 00, 01 and 10 select master operation at single, double and quad speed, and `clk_oe_o` is 1. Pins 11 select slave operation: `clk_oe_o` is 0 and `frame_clk_o`, `bit_clk_o` and `frame_start_o` are held at 0.
- R2: In master operation the frame clock period is 256, 128 or 64 master-clock periods for single, double and quad speed when `fast_mclk_i` is 0. It is twice that when `fast_mclk_i` is 1. One master-clock period is 2 ticks of `clk_i`.
- R3: The bit clock period is 4, 2 or 1 master-clock periods for single, double and quad speed when `fast_mclk_i` is 0, and twice that when it is 1. Every frame therefore holds exactly 64 bit-clock periods.
- R4: Both clocks have a 50% duty cycle. The frame clock is low for the first half of each frame (left channel) and high for the second half (right channel).
- R5: Every transition of the frame clock falls in the same tick as a falling edge of the bit clock.
- R6: `frame_start_o` is 1 for exactly one tick at the start of each left half, that is, in the tick where the frame clock goes low. It is 0 in every other tick.
- R7: `rst_n_i` is an asynchronous active-low reset. While it is low, all four outputs are 0.
- R8: The speed pins and `fast_mclk_i` are sampled on the first rising edge of `clk_i` after reset is released. Later changes on those pins have no effect until the next reset.
- R9: All dividers restart from zero at reset release. In the first tick after the release edge, `frame_start_o` is 1 and both clocks are 0. Instances released on the same edge therefore produce the same phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the master-clock rate |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Speed / ownership select (00 single, 01 double, 10 quad, 11 slave) |
| fast_mclk_i | input | 1 | 1 when the master clock is the fast multiple of Fs |
| frame_clk_o | output | 1 | Frame clock at Fs, low for the left channel |
| bit_clk_o | output | 1 | Bit clock at 64×Fs |
| clk_oe_o | output | 1 | 1 when this block drives the port clocks |
| frame_start_o | output | 1 | One-tick strobe at each left-channel start |

## Verification
All six combinations of master speed and master-clock multiple are run for two full frames. Each tick is compared against a waveform computed from the period formulas, so a wrong pre-divide, a wrong speed tap or a half-period offset appears as a mismatch. Slave operation is run with both values of the fast pin to show that the outputs stay quiet whatever that pin holds. One run flips both configuration pins in the middle of a frame, which separates sampling at reset release from following the pins live. Reset is asserted in the middle of a run to show that it clears the outputs at once, without waiting for a clock edge.

// File: rtl/audio_clk_master_pkg.sv
package audio_clk_master_pkg;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_SLAVE  = 2'b11
  } speed_e;

  typedef struct packed {
    speed_e speed;
    logic   fast;
  } clk_cfg_t;

  localparam clk_cfg_t CFG_RESET = '{speed: SPD_SLAVE, fast: 1'b0};

  // Number of halvings applied relative to single speed.
  function automatic int speed_shift(speed_e s);
    case (s)
      SPD_DOUBLE: return 1;
      SPD_QUAD:   return 2;
      default:    return 0;
    endcase
  endfunction

endpackage

// File: rtl/acm_cfg_latch.sv
module acm_cfg_latch
  import audio_clk_master_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic [1:0] mode_pins_i,
  input  logic       fast_pin_i,
  output clk_cfg_t   cfg_o,
  output logic       run_o
);

  // Configuration is captured on the first edge after release and then frozen.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_o <= 1'b0;
      cfg_o <= CFG_RESET;
    end else begin
      run_o <= 1'b1;
      if (!run_o) begin
        cfg_o <= '{speed: speed_e'(mode_pins_i), fast: fast_pin_i};
      end
    end
  end

endmodule

// File: rtl/acm_tick_counter.sv
module acm_tick_counter
  import audio_clk_master_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             run_i,
  input  clk_cfg_t         cfg_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic advance;
  assign advance = run_i && (cfg_i.speed != SPD_SLAVE);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_o <= '0;
    end else if (advance) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/acm_clock_tap.sv
module acm_clock_tap
  import audio_clk_master_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int BASE_LOG  = 8,
  parameter int FRAME_LOG = 6
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  clk_cfg_t         cfg_i,
  input  logic             run_i,
  output logic             frame_clk_o,
  output logic             bit_clk_o,
  output logic             frame_start_o,
  output logic             master_o
);

  localparam int IDX_W = $clog2(CNT_W);

  int               shift;
  logic [IDX_W-1:0] frame_idx;
  logic [IDX_W-1:0] bit_idx;
  logic [CNT_W-1:0] frame_mask;

  always_comb begin
    shift     = speed_shift(cfg_i.speed);
    frame_idx = IDX_W'(BASE_LOG - shift + int'(cfg_i.fast));
    bit_idx   = IDX_W'(BASE_LOG - FRAME_LOG - shift + int'(cfg_i.fast));
  end

  // Bits of the counter that make up one frame position.
  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign frame_mask[i] = (IDX_W'(i) <= frame_idx);
  end

  assign master_o      = (cfg_i.speed != SPD_SLAVE);
  assign frame_clk_o   = master_o & cnt_i[frame_idx];
  assign bit_clk_o     = master_o & cnt_i[bit_idx];
  assign frame_start_o = master_o & run_i & ~|(cnt_i & frame_mask);

endmodule

// File: rtl/audio_clk_master.sv
module audio_clk_master
  import audio_clk_master_pkg::*;
#(
  parameter int BASE_LR_DIV    = 256,
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic       clk_i,
  input  logic       rst_n_i,
  input  logic [1:0] mode_i,
  input  logic       fast_mclk_i,
  output logic       frame_clk_o,
  output logic       bit_clk_o,
  output logic       clk_oe_o,
  output logic       frame_start_o
);

  localparam int BASE_LOG  = $clog2(BASE_LR_DIV);
  localparam int FRAME_LOG = $clog2(BCLK_PER_FRAME);
  // One bit for the two ticks per master clock, one for the fast pre-divide.
  localparam int CNT_W     = BASE_LOG + 2;

  clk_cfg_t         cfg;
  logic             run;
  logic [CNT_W-1:0] cnt;

  acm_cfg_latch u_cfg (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .mode_pins_i (mode_i),
    .fast_pin_i  (fast_mclk_i),
    .cfg_o       (cfg),
    .run_o       (run)
  );

  acm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .run_i   (run),
    .cfg_i   (cfg),
    .cnt_o   (cnt)
  );

  acm_clock_tap #(
    .CNT_W     (CNT_W),
    .BASE_LOG  (BASE_LOG),
    .FRAME_LOG (FRAME_LOG)
  ) u_tap (
    .cnt_i         (cnt),
    .cfg_i         (cfg),
    .run_i         (run),
    .frame_clk_o   (frame_clk_o),
    .bit_clk_o     (bit_clk_o),
    .frame_start_o (frame_start_o),
    .master_o      (clk_oe_o)
  );

endmodule

// File: rtl/audio_clk_master_chk.sv
module audio_clk_master_chk (
  input logic clk_i,
  input logic rst_n_i,
  input logic frame_clk_o,
  input logic bit_clk_o,
  input logic clk_oe_o,
  input logic frame_start_o
);

  AST_SLAVE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !clk_oe_o |-> (!frame_clk_o && !bit_clk_o && !frame_start_o)); // R1

  AST_FRAME_ON_BIT_FALL: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    ($rose(frame_clk_o) || $fell(frame_clk_o)) |-> $fell(bit_clk_o)); // R5

  AST_STROBE_AT_LEFT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(frame_clk_o) |-> frame_start_o); // R6

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_start_o |=> !frame_start_o); // R6

  AST_STROBE_IN_LEFT: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    frame_start_o |-> !frame_clk_o); // R4

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clk_oe_o |=> clk_oe_o); // R8

endmodule

bind audio_clk_master audio_clk_master_chk u_chk (
  .clk_i         (clk_i),
  .rst_n_i       (rst_n_i),
  .frame_clk_o   (frame_clk_o),
  .bit_clk_o     (bit_clk_o),
  .clk_oe_o      (clk_oe_o),
  .frame_start_o (frame_start_o)
);

// File: tb/audio_clk_master_tb_top.sv
`timescale 1ns/1ps
module audio_clk_master_tb_top;

  logic       clk_i;
  logic       rst_n_i;
  logic [1:0] mode_i;
  logic       fast_mclk_i;
  logic       frame_clk_o, bit_clk_o, clk_oe_o, frame_start_o;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  lr;
    logic  sc;
    logic  fs;
    logic  oe;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;

  audio_clk_master dut_i (
    .clk_i         (clk_i),
    .rst_n_i       (rst_n_i),
    .mode_i        (mode_i),
    .fast_mclk_i   (fast_mclk_i),
    .frame_clk_o   (frame_clk_o),
    .bit_clk_o     (bit_clk_o),
    .clk_oe_o      (clk_oe_o),
    .frame_start_o (frame_start_o)
  );

  initial begin
    clk_i = 1'b0;
    forever #4 clk_i = ~clk_i;
  end

  // Monitor: compares design outputs with the scoreboard, away from the rising edge.
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      checks++;
      if (frame_clk_o !== cur.lr || bit_clk_o !== cur.sc ||
          frame_start_o !== cur.fs || clk_oe_o !== cur.oe) begin
        fails++;
        $display("FAIL %s: got lr=%b sc=%b fs=%b oe=%b, expected lr=%b sc=%b fs=%b oe=%b",
                 cur.tag, frame_clk_o, bit_clk_o, frame_start_o, clk_oe_o,
                 cur.lr, cur.sc, cur.fs, cur.oe);
      end
    end
  end

  task automatic check_quiet(input string tag);
    checks++;
    if (frame_clk_o !== 1'b0 || bit_clk_o !== 1'b0 ||
        frame_start_o !== 1'b0 || clk_oe_o !== 1'b0) begin
      fails++;
      $display("FAIL %s: got lr=%b sc=%b fs=%b oe=%b, expected all 0",
               tag, frame_clk_o, bit_clk_o, frame_start_o, clk_oe_o);
    end
  endtask

  // Driver: resets, configures, releases and pushes the expected waveform.
  task automatic run_case(input int mode, input int fast, input int ncyc, input bit flip_mid);
    int   pl, ps, t;
    exp_t e;
    @(negedge clk_i);
    rst_n_i = 1'b0;
    #1 check_quiet("R7 async clear");
    mode_i      = 2'(mode);
    fast_mclk_i = fast[0];
    @(negedge clk_i);
    check_quiet("R7 held in reset");
    @(negedge clk_i);
    rst_n_i = 1'b1;
    pl = 2 * (256 >> mode) * (fast + 1);
    ps = pl / 64;
    for (int k = 1; k <= ncyc; k++) begin
      @(posedge clk_i);
      #1;
      if (flip_mid && k == ncyc / 2) begin
        mode_i      = ~mode_i;
        fast_mclk_i = ~fast_mclk_i;
      end
      t = k - 1;
      if (mode == 3) begin
        e = '{lr: 1'b0, sc: 1'b0, fs: 1'b0, oe: 1'b0, tag: "R1 slave"};
      end else begin
        e.lr  = ((t % pl) >= pl / 2);
        e.sc  = ((t % ps) >= ps / 2);
        e.fs  = ((t % pl) == 0);
        e.oe  = 1'b1;
        e.tag = flip_mid ? "R8 pins ignored" : "R1 R2 R3 R4 R5 R6 R9";
      end
      exp_q.push_back(e);
    end
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n_i     = 1'b1;
    mode_i      = 2'b11;
    fast_mclk_i = 1'b0;
    #2 rst_n_i = 1'b0;
    @(negedge clk_i);
    check_quiet("R7 reset state");
    for (int m = 0; m < 3; m++) begin
      for (int f = 0; f < 2; f++) begin
        run_case(m, f, 2 * (2 * (256 >> m) * (f + 1)) + 10, 1'b0);
      end
    end
    run_case(1, 0, 2 * 256 + 10, 1'b1);   // R8: configuration frozen after release
    run_case(3, 0, 300, 1'b0);            // R1: slave, slow
    run_case(3, 1, 300, 1'b0);            // R1: slave, fast pin ignored
    run_case(2, 0, 300, 1'b0);            // R9: restart phase after slave period
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule